// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Engine

This block is the device side of a three-wire serial memory link: chip select, serial clock and serial data-in come from an external host, and a single serial data-out line with a separate drive-enable goes back. The engine runs on a fast system clock. All three host lines pass through synchronizers, and the engine acts on rising edges of the serial clock as seen after synchronization. Each instruction is a 1 start bit, a 2-bit opcode and an address. A write instruction then carries a data field. The engine serves reads and writes against an internal byte array.

A width-select input chooses whole words (7-bit word address, 16-bit data) or single bytes (8-bit byte address, 8-bit data). Reads return the addressed word MSB first after one dummy zero. If chip select stays high, the read continues word after word and wraps at the top of the array. A write is stored when chip select falls after the complete data field. A self-timed busy period follows. While it runs, the host can raise chip select and poll data-out: 0 means busy and 1 means ready. A write-enable latch, cleared at reset, gates all writes.

The controller is one state machine:
- `ST_IDLE` waits for a start bit and goes to `ST_OPCODE`.
- `ST_OPCODE` takes two bits and goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_READ` (read), to `ST_DATA` (write with the latch set) or to `ST_WAIT_CS` (anything else).
- `ST_DATA` goes to `ST_WAIT_CS` after the last data bit.
- `ST_WAIT_CS` goes to `ST_BUSY` when chip select falls with a pending write, and to `ST_IDLE` otherwise.
- `ST_BUSY` goes to `ST_READY` if chip select is high when the timer ends, and to `ST_IDLE` otherwise.
- `ST_READY` goes to `ST_IDLE` when chip select falls.
- A chip-select drop in `ST_OPCODE`, `ST_ADDR`, `ST_DATA` or `ST_READ` returns to `ST_IDLE`.

Top module: `uwire_eeprom_slave`

## Requirements
- R1: While chip select is high in the idle state, data-in values of 0 at serial clock rises are skipped. The instruction begins at the first 1.
- R2: Opcode 2'b10 is a read, 2'b01 is a write and 2'b00 is latch control. Opcode 2'b11 is consumed but does nothing: nothing is written and no busy period starts.
- R3: With `org_wide_i` = 1 the address field is 7 bits (word address) and write data is 16 bits. With `org_wide_i` = 0 the address field is 8 bits (byte address) and write data is 8 bits. Word address a covers byte 2a (upper half) and byte 2a+1 (lower half).
- R4: On the serial clock rise that takes the last read address bit, data-out becomes enabled and drives a dummy 0. Each following rise presents the next data bit, MSB first.
- R5: While chip select stays high, a read continues with the next address and no dummy bit. It wraps from the last word (or byte) to address 0.
- R6: A write is stored when chip select falls after the whole data field, and it replaces the old contents directly.
- R7: A latch-control instruction sets the write-enable latch when its first two address bits are 11 and clears it when they are 00. A write while the latch is clear stores nothing and starts no busy period.
- R8: A chip-select drop before an instruction completes aborts it. A write with fewer than the full data bits stores nothing.
- R9: The busy period lasts WRITE_CYCLES system clocks. With chip select high during it, data-out is enabled at 0 and serial traffic is ignored. If chip select is still high when it ends, data-out shows 1 until chip select falls.
- R10: Data-out is disabled while instruction bits are being received, and within one synchronized cycle of chip select going low.
- R11: After reset data-out is disabled and the write-enable latch is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select from host, active high |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| org_wide_i | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes; tie high for the default |
| sdo_o | output | 1 | Serial data to host |
| sdo_en_o | output | 1 | Drive enable for sdo_o (0 = high impedance) |

## Verification
The embedded assertions check the following on every cycle:
- a read always begins with a 0 when data-out turns on;
- the busy period is never left before its timer ends;
- an array write happens only with the latch set, and only in the cycle chip select is first seen low;
- a chip-select drop in a command or read state always returns to idle;
- data-out goes quiet after chip select is low.

Only the directed scenarios can show the stored contents, because they are visible only through later reads. They also cover:
- address wrap;
- skipping of leading zeros;
- the effect of the latch-control address bits;
- that an aborted or opcode-11 instruction leaves memory unchanged.

// File: rtl/uw_pkg.sv
package uw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_WAIT_CS,
        ST_READ,
        ST_BUSY,
        ST_READY
    } uw_state_t;

    localparam logic [1:0] OP_CTRL  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uw_array.sv
module uw_array #(
    parameter int BA_W   = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              wide_i,
    input  logic              we_i,
    input  logic [BA_W-1:0]   addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int HALF_W = WORD_W / 2;
    localparam int DEPTH  = 1 << BA_W;

    logic [HALF_W-1:0] mem [DEPTH];
    logic [BA_W-1:0]   hi_idx, lo_idx;

    assign hi_idx = {addr_i[BA_W-2:0], 1'b0};
    assign lo_idx = {addr_i[BA_W-2:0], 1'b1};

    always_ff @(posedge clk) begin
        if (we_i) begin
            if (wide_i) begin
                mem[hi_idx] <= wdata_i[WORD_W-1:HALF_W];
                mem[lo_idx] <= wdata_i[HALF_W-1:0];
            end else begin
                mem[addr_i] <= wdata_i[HALF_W-1:0];
            end
        end
    end

    always_comb begin
        if (wide_i) rdata_o = {mem[hi_idx], mem[lo_idx]};
        else        rdata_o = {mem[addr_i], {HALF_W{1'b0}}};
    end
endmodule

// File: rtl/uwire_eeprom_slave.sv
module uwire_eeprom_slave
    import uw_pkg::*;
#(
    parameter int ADDR_W       = 7,
    parameter int WORD_W       = 16,
    parameter int WRITE_CYCLES = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic org_wide_i,
    output logic sdo_o,
    output logic sdo_en_o
);
    localparam int BA_W   = ADDR_W + 1;
    localparam int HALF_W = WORD_W / 2;
    localparam int CMAX   = (WORD_W > BA_W) ? WORD_W : BA_W;
    localparam int CNT_W  = $clog2(CMAX + 1);
    localparam int TMR_W  = $clog2(WRITE_CYCLES + 1);

    uw_state_t         state, nxt;
    logic              cs_s, sclk_s, sdi_s, sclk_prev, sk_rise;
    logic [CNT_W-1:0]  cnt, alen_m1, dlen_m1;
    logic [1:0]        op;
    logic [BA_W-1:0]   addr, addr_shift, addr_next;
    logic [1:0]        ctrl_bits;
    logic [WORD_W-1:0] wdata, sh, rdata, wr_word;
    logic [TMR_W-1:0]  tmr;
    logic              org_q, wel, wr_pend, sh_load, sdo_r, wr_en;
    logic              last_a, last_d;

    uw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_i, sclk_i, sdi_i}),
        .q_o   ({cs_s, sclk_s, sdi_s})
    );

    assign wr_word = org_q ? wdata : {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};

    uw_array #(.BA_W(BA_W), .WORD_W(WORD_W)) u_array (
        .clk     (clk),
        .wide_i  (org_q),
        .we_i    (wr_en),
        .addr_i  (addr),
        .wdata_i (wr_word),
        .rdata_o (rdata)
    );

    assign sk_rise    = sclk_s & ~sclk_prev;
    assign alen_m1    = org_q ? CNT_W'(ADDR_W - 1) : CNT_W'(BA_W - 1);
    assign dlen_m1    = org_q ? CNT_W'(WORD_W - 1) : CNT_W'(HALF_W - 1);
    assign last_a     = sk_rise && (cnt == alen_m1);
    assign last_d     = sk_rise && (cnt == dlen_m1);
    assign addr_shift = {addr[BA_W-2:0], sdi_s};
    assign ctrl_bits  = org_q ? addr_shift[ADDR_W-1 -: 2] : addr_shift[BA_W-1 -: 2];
    assign addr_next  = org_q ? {1'b0, addr[ADDR_W-1:0] + ADDR_W'(1)} : addr + BA_W'(1);
    assign wr_en      = (state == ST_WAIT_CS) && !cs_s && wr_pend;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (cs_s && sk_rise && sdi_s) nxt = ST_OPCODE;
            ST_OPCODE:  if (!cs_s) nxt = ST_IDLE;
                        else if (sk_rise && cnt == CNT_W'(1)) nxt = ST_ADDR;
            ST_ADDR:    if (!cs_s) nxt = ST_IDLE;
                        else if (last_a) begin
                            if (op == OP_READ)               nxt = ST_READ;
                            else if (op == OP_WRITE && wel)  nxt = ST_DATA;
                            else                             nxt = ST_WAIT_CS;
                        end
            ST_DATA:    if (!cs_s) nxt = ST_IDLE;
                        else if (last_d) nxt = ST_WAIT_CS;
            ST_WAIT_CS: if (!cs_s) nxt = wr_pend ? ST_BUSY : ST_IDLE;
            ST_READ:    if (!cs_s) nxt = ST_IDLE;
                        else if (sh_load) nxt = ST_READ;
            ST_BUSY:    if (tmr == '0) nxt = cs_s ? ST_READY : ST_IDLE;
            ST_READY:   if (!cs_s) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cnt       <= '0;
            op        <= '0;
            addr      <= '0;
            wdata     <= '0;
            sh        <= '0;
            tmr       <= '0;
            org_q     <= 1'b1;
            wel       <= 1'b0;
            wr_pend   <= 1'b0;
            sh_load   <= 1'b0;
            sdo_r     <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            unique case (state)
                ST_IDLE: begin
                    if (cs_s && sk_rise && sdi_s) begin
                        cnt   <= '0;
                        addr  <= '0;
                        org_q <= org_wide_i;
                    end
                end
                ST_OPCODE: begin
                    if (sk_rise) begin
                        op  <= {op[0], sdi_s};
                        cnt <= (cnt == CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
                    end
                end
                ST_ADDR: begin
                    if (sk_rise) begin
                        addr <= addr_shift;
                        cnt  <= last_a ? '0 : cnt + CNT_W'(1);
                    end
                    if (cs_s && last_a) begin
                        if (op == OP_READ) begin
                            sh_load <= 1'b1;
                            sdo_r   <= 1'b0;
                        end
                        if (op == OP_CTRL && ctrl_bits == 2'b11) wel <= 1'b1;
                        if (op == OP_CTRL && ctrl_bits == 2'b00) wel <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (sk_rise) begin
                        wdata <= {wdata[WORD_W-2:0], sdi_s};
                        cnt   <= last_d ? '0 : cnt + CNT_W'(1);
                    end
                    if (cs_s && last_d) wr_pend <= 1'b1;
                end
                ST_WAIT_CS: begin
                    if (!cs_s) begin
                        wr_pend <= 1'b0;
                        if (wr_pend) tmr <= TMR_W'(WRITE_CYCLES - 1);
                    end
                end
                ST_READ: begin
                    if (sh_load) begin
                        sh      <= rdata;
                        sh_load <= 1'b0;
                    end else if (sk_rise) begin
                        sdo_r <= sh[WORD_W-1];
                        sh    <= {sh[WORD_W-2:0], 1'b0};
                        if (last_d) begin
                            cnt     <= '0;
                            addr    <= addr_next;
                            sh_load <= 1'b1;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_BUSY: begin
                    if (tmr != '0) tmr <= tmr - TMR_W'(1);
                end
                ST_READY: begin
                end
                default: begin
                end
            endcase
            if (!cs_s && state != ST_BUSY && state != ST_WAIT_CS) sh_load <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        sdo_en_o = 1'b0;
        sdo_o    = 1'b0;
        unique case (state)
            ST_READ:  begin sdo_en_o = 1'b1; sdo_o = sdo_r; end
            ST_BUSY:  begin sdo_en_o = cs_s; sdo_o = 1'b0;  end
            ST_READY: begin sdo_en_o = 1'b1; sdo_o = 1'b1;  end
            default:  begin sdo_en_o = 1'b0; sdo_o = 1'b0;  end
        endcase
    end

    AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sdo_en_o) && state == ST_READ) |-> !sdo_o);  // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && tmr != '0) |=> state == ST_BUSY);  // R9
    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wel);  // R7
    AST_COMMIT_ON_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $fell(cs_s));  // R6
    AST_CS_DROP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && (state == ST_OPCODE || state == ST_ADDR || state == ST_DATA
                   || state == ST_READ)) |=> state == ST_IDLE);  // R8
    AST_QUIET_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (!sdo_en_o || cs_s));  // R10
endmodule

// File: tb/tb_uwire_eeprom_slave.sv
module tb_uwire_eeprom_slave;
    localparam int WC = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic sdo, sdo_en;
    logic smp_en, smp_d;
    logic [7:0] model [256];
    int errs = 0, checks = 0;

    always #2 clk = ~clk;

    uwire_eeprom_slave #(.WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sk), .sdi_i(di),
        .org_wide_i(org), .sdo_o(sdo), .sdo_en_o(sdo_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b);
        @(negedge clk) di = b;
        repeat (8) @(negedge clk);
        sk = 1'b1;
        repeat (7) @(negedge clk);
        smp_en = sdo_en;
        smp_d  = sdo;
        @(negedge clk) sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
    endtask

    task automatic cs_on();
        @(negedge clk) cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk) cs = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    function automatic int aw(input logic wide); return wide ? 7 : 8; endfunction
    function automatic int dw(input logic wide); return wide ? 16 : 8; endfunction

    task automatic set_wel(input logic on);
        org = 1'b1;
        cs_on();
        send(3'b100, 3);
        send(on ? 32'b1100000 : 32'b0000000, 7);
        cs_off();
    endtask

    // R6 / R7 / R9 / R10: full write, then busy and ready polling
    task automatic t_write(input logic [7:0] a, input logic [15:0] d, input logic wide,
                           input logic commit, input string tag);
        org = wide;
        cs_on();
        send(3'b101, 3);
        send(a, aw(wide));
        send(d, dw(wide));
        cs_off();
        @(negedge clk) cs = 1'b1;
        repeat (6) @(negedge clk);
        if (commit) check("R9 busy", {sdo_en, sdo}, 2'b10);
        else        check(tag, sdo_en, 1'b0);
        repeat (WC + 20) @(negedge clk);
        if (commit) check("R9 ready", {sdo_en, sdo}, 2'b11);
        cs_off();
        check("R10 quiet", sdo_en, 1'b0);
        if (commit) begin
            if (wide) begin
                model[{a[6:0], 1'b0}] = d[15:8];
                model[{a[6:0], 1'b1}] = d[7:0];
            end else begin
                model[a] = d[7:0];
            end
        end
    endtask

    // R1 / R3 / R4 / R5: read with optional leading zeros, n words
    task automatic t_read(input logic [7:0] a, input logic wide, input int n, input int lz);
        logic [15:0] got, exp;
        int idx;
        org = wide;
        cs_on();
        if (lz > 0) send(32'd0, lz);
        send(3'b110, 3);
        send(a >> 1, aw(wide) - 1);
        check("R10 hiz in command", smp_en, 1'b0);
        sk_bit(a[0]);
        check(lz > 0 ? "R1 dummy after zeros" : "R4 dummy", {smp_en, smp_d}, 2'b10);
        for (int w = 0; w < n; w++) begin
            got = '0;
            for (int b = 0; b < dw(wide); b++) begin
                sk_bit(1'b0);
                got = {got[14:0], smp_d};
            end
            if (wide) begin
                idx = (a + w) % 128;
                exp = {model[2 * idx], model[2 * idx + 1]};
            end else begin
                idx = (a + w) % 256;
                exp = {8'h00, model[idx]};
            end
            check(w > 0 ? "R5 sequential" : (wide ? "R4 word" : "R3 byte"), got, exp);
        end
        cs_off();
        check("R10 quiet", sdo_en, 1'b0);
    endtask

    // R8: partial write aborted by chip-select drop
    task automatic t_abort(input logic [7:0] a);
        org = 1'b1;
        cs_on();
        send(3'b101, 3);
        send(a, 7);
        send(8'hFF, 8);
        cs_off();
        @(negedge clk) cs = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 no busy", sdo_en, 1'b0);
        cs_off();
        t_read(a, 1'b1, 1, 0);
    endtask

    // R2: opcode 11 does nothing
    task automatic t_op11(input logic [7:0] a);
        org = 1'b1;
        cs_on();
        send(3'b111, 3);
        send(a, 7);
        send(16'h0000, 16);
        cs_off();
        @(negedge clk) cs = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 op11 no busy", sdo_en, 1'b0);
        cs_off();
        t_read(a, 1'b1, 1, 0);
    endtask

    // R9: traffic during busy is ignored
    task automatic t_busy_ignore(input logic [7:0] a, input logic [15:0] d);
        org = 1'b1;
        cs_on();
        send(3'b101, 3);
        send(a, 7);
        send(d, 16);
        cs_off();
        @(negedge clk) cs = 1'b1;
        repeat (4) @(negedge clk);
        send(3'b110, 3);
        check("R9 busy during traffic", {smp_en, smp_d}, 2'b10);
        send(7'h12, 7);
        repeat (WC) @(negedge clk);
        check("R9 ready after traffic", {sdo_en, sdo}, 2'b11);
        cs_off();
        model[{a[6:0], 1'b0}] = d[15:8];
        model[{a[6:0], 1'b1}] = d[7:0];
        t_read(a, 1'b1, 1, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 reset quiet", sdo_en, 1'b0);
        t_write(8'h05, 16'h1111, 1'b1, 1'b0, "R11 latch clear at reset");
        set_wel(1'b1);
        t_write(8'h12, 16'hA5C3, 1'b1, 1'b1, "");
        t_read(8'h12, 1'b1, 1, 0);
        t_write(8'h7F, 16'h1234, 1'b1, 1'b1, "");
        t_write(8'h00, 16'hBEEF, 1'b1, 1'b1, "");
        t_read(8'h7F, 1'b1, 2, 0);
        t_write(8'h12, 16'h0F0F, 1'b1, 1'b1, "");
        t_read(8'h12, 1'b1, 1, 3);
        t_write(8'h25, 16'h003C, 1'b0, 1'b1, "");
        t_read(8'h25, 1'b0, 1, 0);
        t_read(8'h24, 1'b0, 2, 0);
        t_read(8'h12, 1'b1, 1, 0);
        t_write(8'hFF, 16'h005A, 1'b0, 1'b1, "");
        t_write(8'h01, 16'h00C7, 1'b0, 1'b1, "");
        t_write(8'h00, 16'h0011, 1'b0, 1'b1, "");
        t_read(8'hFF, 1'b0, 3, 0);
        t_abort(8'h12);
        t_op11(8'h12);
        t_busy_ignore(8'h40, 16'h6D2B);
        set_wel(1'b0);
        t_write(8'h12, 16'hFFFF, 1'b1, 1'b0, "R7 latch cleared");
        t_read(8'h12, 1'b1, 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule